// File: doc/BRIEF.md
# General-Purpose PWM Timer

This block is a general-purpose timer built around a 16-bit counter that reloads itself at a programmable limit, fed by a 16-bit prescaler. The counter can run upward, downward, or up and then down in a triangle (centre-aligned) pattern. Four channels watch the counter. Each channel can be idle, capture the counter on an input edge, toggle an output when the counter hits a stored value, or produce pulse-width modulation. The PWM is edge-aligned when the counter runs in one direction and centre-aligned when it runs as a triangle.

Software configures the timer through a flat register port. Addresses: 0 control, 1 prescaler, 2 reload limit, 3 counter, 4 event generation, 5 status, 6 channel configuration, 7 event enables, 8 to 11 channel compare/capture values. A reload event, a trigger event and the four channel events each set a sticky status flag. Each event can also raise a one-cycle interrupt pulse and a one-cycle DMA request pulse, under separate enable masks. A rising edge on the trigger input, or a software trigger, restarts the counter and sets it running. A one-shot option stops the counter after one full period.

Top module: `tmr_gp`

## Requirements
- R1: After reset every register reads zero, the counter is stopped, and ch_out, irq and dma_req are low.
- R2: In up mode (control bits [2:1]=0) the counter steps from 0 to the reload limit ARR and wraps to 0. The wrap raises the reload event, once every (PSC+1)*(ARR+1) clocks.
- R3: In down mode (control bits [2:1]=1) the counter steps from ARR to 0 and reloads ARR. The reload raises the reload event with the same period as R2. The direction bit (control bit 4) reads 1.
- R4: In centre mode (control bits [2:1]=2) the counter rises to ARR and falls to 0. A reload event occurs at both turning points, so there are two events every 2*ARR*(PSC+1) clocks.
- R5: A value written to the prescaler register takes effect only at the next reload event or reinitialisation.
- R6: In PWM mode (channel mode 3) the channel output is high while the counter is below the channel value. A value of 0 keeps it low, and a value above ARR keeps it high. Over one period, the number of high clocks is min(CCR,ARR+1) in up and down modes, and 2*CCR-1 (capped at 2*ARR) in centre mode.
- R7: In compare mode (channel mode 2) the output toggles, and the channel flag sets, when the counter reaches the channel value.
- R8: In capture mode (channel mode 1) the channel latches the counter on the rising edge of its input, or on the falling edge when polarity bit 2 of its field is 1. The other edge is ignored. Channel i's 3-bit field sits at configuration bits [3i+2:3i].
- R9: A capture that arrives while the channel's flag (status bit 2+i) is still set also sets its overcapture flag (status bit 6+i).
- R10: With the one-shot bit (control bit 3) set, the counter clears the run bit (control bit 0) at the end of its first period. In up mode it is left at 0.
- R11: Writing bit 0 of the event register reinitialises the counter (to 0, or to ARR in down mode) and raises a reload event. A software trigger (bit 1) or a rising edge on trig_in does the same, also sets the run bit, and raises the trigger event (status bit 1).
- R12: The direction bit is read-only. Writes to it have no effect.
- R13: Status flags are cleared by writing 1 to them. The event-enable register gates irq (bits [5:0]) and dma_req (bits [11:6]) per event, in the order reload, trigger, channels 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr |
| trig_in | input | 1 | External trigger, rising edge restarts the counter |
| ch_in | input | 4 | Capture inputs, one per channel |
| ch_out | output | 4 | Compare/PWM outputs, one per channel |
| irq | output | 1 | Interrupt pulse for any enabled event |
| dma_req | output | 6 | DMA request pulses per event |

## Verification
A wrong counter state shows up as a shifted reload-event period, or as a maximum count that differs from ARR. Either is visible within one timer period, because dma_req[0] pulses at every reload. A stale prescaler or direction register changes the spacing between consecutive reload pulses, or the PWM high-time count, within the next period. Capture and flag errors show up at once in the channel value and status readback, a few clocks after the input edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    CM_UP     = 2'd0,
    CM_DOWN   = 2'd1,
    CM_CENTER = 2'd2
  } cnt_mode_e;

  typedef enum logic [1:0] {
    CH_OFF     = 2'd0,
    CH_CAPTURE = 2'd1,
    CH_COMPARE = 2'd2,
    CH_PWM     = 2'd3
  } ch_mode_e;

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_PSC    = 4'd1;
  localparam logic [3:0] A_ARR    = 4'd2;
  localparam logic [3:0] A_CNT    = 4'd3;
  localparam logic [3:0] A_EVGEN  = 4'd4;
  localparam logic [3:0] A_STATUS = 4'd5;
  localparam logic [3:0] A_CHCFG  = 4'd6;
  localparam logic [3:0] A_EVEN   = 4'd7;
  localparam logic [3:0] A_CCR0   = 4'd8;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] shadow,
  output logic         tick
);
  logic [W-1:0] div_q, div_d, act_q, act_d;

  assign tick = run && (div_q == act_q);

  always_comb begin
    div_d = div_q;
    act_d = act_q;
    if (restart) begin
      div_d = '0;
      act_d = shadow;
    end else if (run) begin
      div_d = tick ? '0 : div_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      act_q <= '0;
    end else begin
      div_q <= div_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter import tmr_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reinit,
  input  cnt_mode_e    mode,
  input  logic [W-1:0] arr,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic         upd,
  output logic         period_end
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         dn_q, dn_d;

  always_comb begin
    cnt_d      = cnt_q;
    dn_d       = dn_q;
    upd        = 1'b0;
    period_end = 1'b0;
    if (wr_cnt) begin
      cnt_d = wr_val;
    end else if (reinit) begin
      cnt_d = (mode == CM_DOWN) ? arr : '0;
      dn_d  = 1'b0;
    end else if (tick) begin
      case (mode)
        CM_DOWN: begin
          if (cnt_q == '0) begin
            cnt_d = arr; upd = 1'b1; period_end = 1'b1;
          end else cnt_d = cnt_q - W'(1);
        end
        CM_CENTER: begin
          if (arr == '0) cnt_d = '0;
          else if (!dn_q) begin
            if (cnt_q >= arr) begin
              cnt_d = arr - W'(1); dn_d = 1'b1; upd = 1'b1;
            end else cnt_d = cnt_q + W'(1);
          end else begin
            if (cnt_q == '0) begin
              cnt_d = W'(1); dn_d = 1'b0; upd = 1'b1; period_end = 1'b1;
            end else cnt_d = cnt_q - W'(1);
          end
        end
        default: begin
          if (cnt_q >= arr) begin
            cnt_d = '0; upd = 1'b1; period_end = 1'b1;
          end else cnt_d = cnt_q + W'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign cnt  = cnt_q;
  assign down = (mode == CM_DOWN) || ((mode == CM_CENTER) && dn_q);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ch_mode_e     mode,
  input  logic         fall_sel,
  input  logic         pin,
  input  logic [W-1:0] cnt,
  input  logic         wr_ccr,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] ccr,
  output logic         out,
  output logic         evt
);
  logic         s1_q, s2_q, prev_q, out_q, out_d, hit_q;
  logic [W-1:0] ccr_q, ccr_d;
  logic         edge_ok, hit, cap, cmp_evt;

  always_comb begin
    edge_ok = fall_sel ? (prev_q && !s2_q) : (!prev_q && s2_q);
    hit     = (cnt == ccr_q);
    cap     = (mode == CH_CAPTURE) && edge_ok;
    cmp_evt = ((mode == CH_COMPARE) || (mode == CH_PWM)) && hit && !hit_q;
    ccr_d   = wr_ccr ? wr_val : (cap ? cnt : ccr_q);
    case (mode)
      CH_PWM:     out_d = (cnt < ccr_q);
      CH_COMPARE: out_d = cmp_evt ? !out_q : out_q;
      default:    out_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      ccr_q  <= '0;
      out_q  <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      ccr_q  <= ccr_d;
      out_q  <= out_d;
      hit_q  <= hit;
    end
  end

  assign ccr = ccr_q;
  assign out = out_q;
  assign evt = cap || cmp_evt;
endmodule

// File: rtl/tmr_gp.sv
module tmr_gp import tmr_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int NCH   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         addr,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   rd_data,
  input  logic               trig_in,
  input  logic [NCH-1:0]     ch_in,
  output logic [NCH-1:0]     ch_out,
  output logic               irq,
  output logic [2+NCH-1:0]   dma_req
);
  localparam int NEV   = 2 + NCH;
  localparam int CFG_W = 3 * NCH;

  logic             run_q, run_d, opm_q, opm_d;
  cnt_mode_e        mode_q, mode_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [CNT_W-1:0] arr_q, arr_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [2*NEV-1:0] en_q, en_d;
  logic [NEV-1:0]   flags_q, flags_d, evt, dma_d;
  logic [NCH-1:0]   ovc_q, ovc_d, cc_evt, ovc_set;
  logic             irq_q, irq_d;
  logic             trg_s1, trg_s2, trg_p;
  logic             sw_upd, trg, reinit, tick, upd_cnt, period_end, dn;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ccr [NCH];

  assign sw_upd = wr_en && (addr == A_EVGEN) && wr_data[0];
  assign trg    = (wr_en && (addr == A_EVGEN) && wr_data[1]) || (trg_s2 && !trg_p);
  assign reinit = sw_upd || trg;

  tmr_prescaler #(.W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .restart(reinit || upd_cnt),
    .shadow(psc_q), .tick(tick)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reinit(reinit), .mode(mode_q),
    .arr(arr_q), .wr_cnt(wr_en && (addr == A_CNT)), .wr_val(wr_data),
    .cnt(cnt), .down(dn), .upd(upd_cnt), .period_end(period_end)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .mode(ch_mode_e'(cfg_q[3*i +: 2])), .fall_sel(cfg_q[3*i+2]),
      .pin(ch_in[i]), .cnt(cnt),
      .wr_ccr(wr_en && (addr == A_CCR0 + 4'(i))), .wr_val(wr_data),
      .ccr(ccr[i]), .out(ch_out[i]), .evt(cc_evt[i])
    );
    assign ovc_set[i] = cc_evt[i] && (cfg_q[3*i +: 2] == CH_CAPTURE) && flags_q[2+i];
  end

  assign evt = {cc_evt, trg, upd_cnt || reinit};

  always_comb begin
    run_d  = run_q;
    opm_d  = opm_q;
    mode_d = mode_q;
    psc_d  = psc_q;
    arr_d  = arr_q;
    cfg_d  = cfg_q;
    en_d   = en_q;
    flags_d = flags_q;
    ovc_d   = ovc_q;
    if (period_end && opm_q) run_d = 1'b0;
    if (trg) run_d = 1'b1;
    if (wr_en) begin
      case (addr)
        A_CTRL: begin
          run_d  = wr_data[0];
          mode_d = cnt_mode_e'(wr_data[2:1]);
          opm_d  = wr_data[3];
        end
        A_PSC:    psc_d = wr_data[PSC_W-1:0];
        A_ARR:    arr_d = wr_data;
        A_CHCFG:  cfg_d = wr_data[CFG_W-1:0];
        A_EVEN:   en_d  = wr_data[2*NEV-1:0];
        A_STATUS: begin
          flags_d = flags_q & ~wr_data[NEV-1:0];
          ovc_d   = ovc_q & ~wr_data[NEV+NCH-1:NEV];
        end
        default: ;
      endcase
    end
    flags_d = flags_d | evt;
    ovc_d   = ovc_d | ovc_set;
    irq_d   = |(evt & en_q[NEV-1:0]);
    dma_d   = evt & en_q[2*NEV-1:NEV];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;  opm_q <= 1'b0;  mode_q <= CM_UP;
      psc_q <= '0;    arr_q <= '0;    cfg_q  <= '0;   en_q <= '0;
      flags_q <= '0;  ovc_q <= '0;    irq_q  <= 1'b0; dma_req <= '0;
      trg_s1 <= 1'b0; trg_s2 <= 1'b0; trg_p  <= 1'b0;
    end else begin
      run_q <= run_d;  opm_q <= opm_d;  mode_q <= mode_d;
      psc_q <= psc_d;  arr_q <= arr_d;  cfg_q  <= cfg_d;  en_q <= en_d;
      flags_q <= flags_d; ovc_q <= ovc_d; irq_q <= irq_d; dma_req <= dma_d;
      trg_s1 <= trig_in; trg_s2 <= trg_s1; trg_p <= trg_s2;
    end
  end

  assign irq = irq_q;

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL:   rd_data[4:0] = {dn, opm_q, mode_q, run_q};
      A_PSC:    rd_data[PSC_W-1:0] = psc_q;
      A_ARR:    rd_data = arr_q;
      A_CNT:    rd_data = cnt;
      A_STATUS: rd_data[NEV+NCH-1:0] = {ovc_q, flags_q};
      A_CHCFG:  rd_data[CFG_W-1:0] = cfg_q;
      A_EVEN:   rd_data[2*NEV-1:0] = en_q;
      default: begin
        for (int i = 0; i < NCH; i++)
          if (addr == A_CCR0 + 4'(i)) rd_data = ccr[i];
      end
    endcase
  end
endmodule

// File: rtl/tmr_gp_chk.sv
module tmr_gp_chk import tmr_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int NCH   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [3:0]       addr,
  input logic [1:0]       mode,
  input logic             upd_cnt,
  input logic             period_end,
  input logic             opm,
  input logic             run,
  input logic             trg,
  input logic             dn,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] ccr0,
  input logic [1:0]       ch0_mode,
  input logic             ch0_out,
  input logic [NCH-1:0]   ccf,
  input logic [NCH-1:0]   ovc
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr == A_CTRL);

  AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_UP && upd_cnt) |=> (cnt == '0)); // R2

  AST_CENTER_TOP_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_CENTER && upd_cnt && !dn && !ctrl_wr) |=> dn); // R4

  AST_PWM_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ch0_mode == CH_PWM && ccr0 == '0 && !wr_en) |=> !ch0_out); // R6

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (opm && period_end && !trg && !ctrl_wr) |=> !run); // R10

  for (genvar i = 0; i < NCH; i++) begin : g_ovc
    AST_OVC_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovc[i]) |-> $past(ccf[i])); // R9
  end
endmodule

bind tmr_gp tmr_gp_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .mode(mode_q),
  .upd_cnt(upd_cnt), .period_end(period_end), .opm(opm_q), .run(run_q),
  .trg(trg), .dn(dn), .cnt(cnt), .ccr0(ccr[0]), .ch0_mode(cfg_q[1:0]),
  .ch0_out(ch_out[0]), .ccf(flags_q[2+NCH-1:2]), .ovc(ovc_q)
);

// File: tb/tmr_gp_bench.sv
module tmr_gp_bench;
  localparam logic [3:0] A_CTRL = 0, A_PSC = 1, A_ARR = 2, A_CNT = 3, A_EVGEN = 4,
                         A_STATUS = 5, A_CHCFG = 6, A_EVEN = 7, A_CCR0 = 8;

  logic        clk, rst_n, wr_en, trig_in, irq;
  logic [3:0]  addr, ch_in, ch_out;
  logic [15:0] wr_data, rd_data;
  logic [5:0]  dma_req;

  int n_run, n_fail, cyc;
  int w_upd, w_trg, w_irq, w_dma, w_hi0, w_tog1, w_max;
  logic [15:0] rv;

  tmr_gp u_tmr_gp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .trig_in(trig_in), .ch_in(ch_in), .ch_out(ch_out),
    .irq(irq), .dma_req(dma_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic run_window(input int n);
    logic p1;
    w_upd = 0; w_trg = 0; w_irq = 0; w_dma = 0; w_hi0 = 0; w_tog1 = 0; w_max = 0;
    addr = A_CNT;
    p1 = ch_out[1];
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (dma_req[0]) w_upd++;
      if (dma_req[1]) w_trg++;
      if (irq) w_irq++;
      if (|dma_req) w_dma++;
      if (ch_out[0]) w_hi0++;
      if (ch_out[1] != p1) w_tog1++;
      p1 = ch_out[1];
      if (int'(rd_data) > w_max) w_max = int'(rd_data);
    end
  endtask

  task automatic setup(input int mode, input int psc, input int arr);
    wr(A_CTRL, 16'(mode << 1));
    wr(A_PSC, 16'(psc));
    wr(A_ARR, 16'(arr));
    wr(A_EVGEN, 16'h1);
    wr(A_CTRL, 16'((mode << 1) | 1));
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int per, exp, t0, t1, t2;
    n_run = 0; n_fail = 0; cyc = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0; trig_in = 1'b0; ch_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ch_out, 0, "R1 ch_out");
    check(irq, 0, "R1 irq");
    check(dma_req, 0, "R1 dma_req");
    rd(A_CTRL, rv);   check(rv, 0, "R1 ctrl");
    rd(A_CNT, rv);    check(rv, 0, "R1 cnt");
    rd(A_STATUS, rv); check(rv, 0, "R1 status");

    wr(A_EVEN, 16'h0FC0);
    // R2 up, R3 down sweeps
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 3; p++)
        for (int a = 1; a < 9; a = a * 2 + 1) begin
          setup(m, p, a);
          per = (p + 1) * (a + 1);
          repeat (2 * per) @(negedge clk);
          run_window(4 * per);
          check(w_upd, 4, m == 0 ? "R2 up reload count" : "R3 down reload count");
          check(w_max, a, m == 0 ? "R2 up max" : "R3 down max");
        end
    rd(A_CTRL, rv); check(rv[4], 1, "R3 dir bit in down mode");

    // R4 centre sweep
    for (int p = 0; p < 2; p++)
      for (int a = 1; a < 9; a = a * 2 + 1) begin
        setup(2, p, a);
        per = 2 * a * (p + 1);
        repeat (2 * per) @(negedge clk);
        run_window(3 * per);
        check(w_upd, 6, "R4 centre reload count");
        check(w_max, a, "R4 centre max");
      end

    // R6 PWM duty sweep on channel 0, ARR=5
    wr(A_CHCFG, 16'h0003);
    for (int m = 0; m < 3; m++)
      for (int c = 0; c < 8; c++) begin
        setup(m, 0, 5);
        wr(A_CCR0, 16'(c));
        per = (m == 2) ? 10 : 6;
        repeat (2 * per) @(negedge clk);
        run_window(2 * per);
        if (m == 2) exp = (c == 0) ? 0 : (c > 5 ? 20 : 2 * (2 * c - 1));
        else exp = 2 * ((c < 6) ? c : 6);
        check(w_hi0, exp, "R6 pwm high count");
      end

    // R7 compare toggle on channel 1
    wr(A_CTRL, 16'h0);
    wr(A_CHCFG, 16'(2 << 3));
    wr(A_CCR0 + 1, 16'd9);
    wr(A_CNT, 16'd4);
    wr(A_STATUS, 16'hFFFF);
    repeat (2) @(negedge clk);
    t0 = ch_out[1];
    wr(A_CNT, 16'd9);
    repeat (3) @(negedge clk);
    check(ch_out[1], !t0, "R7 toggle on match");
    rd(A_STATUS, rv); check(rv[3], 1, "R7 channel flag");
    setup(0, 0, 15);
    repeat (20) @(negedge clk);
    run_window(48);
    check(w_tog1, 3, "R7 toggles per period");

    // R8 capture on channel 2
    wr(A_CTRL, 16'h0);
    wr(A_CHCFG, 16'(1 << 6));
    wr(A_CNT, 16'd123);
    wr(A_STATUS, 16'hFFFF);
    ch_in[2] = 1'b1; repeat (5) @(negedge clk);
    rd(A_CCR0 + 2, rv); check(rv, 123, "R8 rising capture");
    rd(A_STATUS, rv); check(rv[4], 1, "R8 capture flag");
    wr(A_CNT, 16'd200);
    ch_in[2] = 1'b0; repeat (5) @(negedge clk);
    rd(A_CCR0 + 2, rv); check(rv, 123, "R8 falling edge ignored");
    wr(A_CHCFG, 16'(5 << 6));
    wr(A_CNT, 16'd300);
    ch_in[2] = 1'b1; repeat (5) @(negedge clk);
    rd(A_CCR0 + 2, rv); check(rv, 123, "R8 rising edge ignored");
    ch_in[2] = 1'b0; repeat (5) @(negedge clk);
    rd(A_CCR0 + 2, rv); check(rv, 300, "R8 falling capture");

    // R9 overcapture, R13 write-one-to-clear
    wr(A_STATUS, 16'hFFFF);
    ch_in[2] = 1'b1; repeat (5) @(negedge clk);
    ch_in[2] = 1'b0; repeat (5) @(negedge clk);
    rd(A_STATUS, rv); check(rv[8], 0, "R9 no overcapture on first");
    ch_in[2] = 1'b1; repeat (5) @(negedge clk);
    ch_in[2] = 1'b0; repeat (5) @(negedge clk);
    rd(A_STATUS, rv); check(rv[8], 1, "R9 overcapture set");
    wr(A_STATUS, 16'hFFFF);
    rd(A_STATUS, rv); check(rv, 0, "R13 status cleared");

    // R10 one-shot started by trig_in, R11 trigger
    wr(A_CHCFG, 16'h0);
    wr(A_CTRL, 16'h0008);
    wr(A_PSC, 16'd0);
    wr(A_ARR, 16'd5);
    trig_in = 1'b1;
    run_window(40);
    trig_in = 1'b0;
    check(w_upd, 2, "R10 reloads in one shot");
    check(w_trg, 1, "R11 trigger event");
    rd(A_CTRL, rv); check(rv[0], 0, "R10 run cleared");
    rd(A_CNT, rv); check(rv, 0, "R10 counter parked");
    rd(A_STATUS, rv); check(rv[1], 1, "R11 trigger flag");

    // R11 software reinit
    setup(0, 0, 100);
    repeat (30) @(negedge clk);
    wr(A_EVGEN, 16'h1);
    rd(A_CNT, rv); check(rv, 0, "R11 reinit up");
    wr(A_CTRL, 16'h3);
    repeat (30) @(negedge clk);
    wr(A_EVGEN, 16'h1);
    rd(A_CNT, rv); check(rv, 100, "R11 reinit down");
    wr(A_CTRL, 16'h0);
    wr(A_EVGEN, 16'h2);
    rd(A_CTRL, rv); check(rv[0], 1, "R11 software trigger starts");

    // R5 prescaler on the fly
    setup(0, 0, 9);
    do @(negedge clk); while (!dma_req[0]);
    t0 = cyc;
    wr(A_PSC, 16'd3);
    do @(negedge clk); while (!dma_req[0]);
    t1 = cyc;
    do @(negedge clk); while (!dma_req[0]);
    t2 = cyc;
    check(t1 - t0, 10, "R5 old ratio until reload");
    check(t2 - t1, 40, "R5 new ratio after reload");

    // R12 direction read-only
    wr(A_CTRL, 16'h0010);
    rd(A_CTRL, rv); check(rv[4], 0, "R12 dir write ignored up");
    wr(A_CTRL, 16'h0002);
    rd(A_CTRL, rv); check(rv[4], 1, "R12 dir write ignored down");

    // R13 enable gating
    wr(A_EVEN, 16'h0001);
    setup(0, 0, 3);
    repeat (8) @(negedge clk);
    run_window(16);
    check(w_irq, 4, "R13 irq pulses");
    check(w_dma, 0, "R13 dma masked");
    wr(A_EVEN, 16'h0);
    run_window(16);
    check(w_irq, 0, "R13 irq masked");

    finish_run();
  end
endmodule